// File: doc/BRIEF.md
# Instruction Translation Filter with TLB Sleep Control

This block sits between instruction fetch and a small fully associative instruction TLB. It keeps the most recently used virtual-to-physical page translation in a single-entry buffer. Fetches to the same page are translated from that buffer in the cycle they are presented, and the TLB array behind it stays in a low-leakage sleep state.

A fetch that misses the buffer wakes the whole TLB. After a fixed wake-up delay the block searches every TLB entry at once and returns the translation, or a fault when no entry matches. A hit refills the buffer. Software loads TLB entries through a refill port, and a flush input clears every cached translation, including the buffered one. Three counters report buffer hits, TLB lookups and the cycles the TLB spends asleep, which gives the filtering ratio.

Top module: `xfilt_top`

## Requirements
- R1: A fetch whose VPN equals the VPN of a valid buffered translation completes in the cycle it is presented (fetchReady high). It returns the buffered PPN with xlatFault low and does not perform a TLB lookup.
- R2: A buffer-missing fetch presented while the TLB sleeps is stalled with fetchReady low. It completes exactly WAKE_CYCLES+1 cycles after it is first presented.
- R3: A TLB lookup compares the fetch VPN against all valid entries and returns the PPN of the match. When several valid entries hold the same VPN, the lowest index wins.
- R4: A TLB lookup with no matching valid entry completes with xlatFault high and xlatPpn zero, and leaves the buffer unchanged.
- R5: A TLB lookup that hits loads the buffer with that VPN and PPN, so the next fetch to the same page is a buffer hit (R1).
- R6: When the TLB is awake and performs no lookup and no refill in a cycle, it is asleep (tlbSleep high) from the next cycle. A buffer miss presented while the TLB is still awake is looked up in that same cycle.
- R7: No TLB lookup is ever counted in a cycle in which tlbSleep is high.
- R8: While flush is high, no fetch and no refill completes. After a flush the buffer and all TLB entries are invalid, so previously mapped pages fault.
- R9: A refill writes VPN and PPN into entry fillIdx and marks it valid. It completes (fillReady high) only while the TLB is awake. A refill presented while asleep wakes the TLB and completes WAKE_CYCLES+1 cycles later.
- R10: A completed refill whose VPN equals the buffered VPN also replaces the buffered PPN. A buffer-hit fetch in that same cycle still returns the old PPN.
- R11: When a buffer-missing fetch and a refill are both pending in an awake cycle, the refill completes first. The lookup follows in the next cycle and sees the refilled entry.
- R12: hitCount increments once per buffer-hit completion. accessCount increments once per TLB lookup. sleepCount increments once per cycle with tlbSleep high.
- R13: After reset the TLB is asleep, all counters are zero, and the buffer and all entries are invalid, so the first fetch (including VPN 0) goes to the TLB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | Fetch translation request, held until fetchReady |
| fetchVpn | input | VPN_W | Virtual page number of the fetch |
| fetchReady | output | 1 | Request completes this cycle; xlatPpn/xlatFault valid |
| xlatPpn | output | PPN_W | Translated physical page number |
| xlatFault | output | 1 | TLB miss exception for the completing fetch |
| flush | input | 1 | Invalidate buffer and all TLB entries |
| fillValid | input | 1 | Refill request, held until fillReady |
| fillIdx | input | IDX_W | TLB entry index to write |
| fillVpn | input | VPN_W | Virtual page number to write |
| fillPpn | input | PPN_W | Physical page number to write |
| fillReady | output | 1 | Refill is written this cycle |
| tlbSleep | output | 1 | TLB array is in low-leakage mode |
| hitCount | output | CNT_W | Buffer-hit completions |
| accessCount | output | CNT_W | TLB lookups performed |
| sleepCount | output | CNT_W | Cycles spent asleep |

## Verification
A refill and a buffer-hit fetch can complete in the same cycle when both name the buffered page. The bench provokes this twice. The first time the TLB is already awake, so both finish in one cycle. The second time the TLB is asleep, so the hit finishes at once while the refill waits for wake-up. In both cases the hit must return the old PPN, and the next fetch to that page must return the refilled PPN without a lookup. A refill and a buffer-missing lookup pending together in an awake cycle are also judged: fetchReady stays low for one cycle and the lookup then returns the new entry. Expected values come from a bench model of the entries and the buffer, with a sweep over every VPN of a 6-bit configuration.

// File: rtl/xfilt_pkg.sv
package xfilt_pkg;

  typedef enum logic [1:0] {
    PWR_SLEEP = 2'd0,
    PWR_WAKE  = 2'd1,
    PWR_AWAKE = 2'd2
  } pwr_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic lookup;    // search the array and maybe load the buffer
    logic fill;      // write one array entry
    logic flush;     // invalidate everything
    logic cntHit;    // a fetch completes from the buffer
    logic cntSleep;  // array is asleep this cycle
  } xfilt_stb_t;

endpackage

// File: rtl/xfilt_ctrl.sv
module xfilt_ctrl
  import xfilt_pkg::*;
#(
  parameter int WAKE_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchValid,
  input  logic       flush,
  input  logic       fillValid,
  input  logic       bufHit,
  output logic       fetchReady,
  output logic       fillReady,
  output logic       tlbSleep,
  output xfilt_stb_t stb
);

  localparam int WCNT_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES + 1) : 1;

  pwr_state_e        state, stateNext;
  logic [WCNT_W-1:0] wakeCnt, wakeCntNext;
  logic              awake, hitPath, fillGo, lookGo, needTlb;

  always_comb begin
    awake   = (state == PWR_AWAKE);
    hitPath = fetchValid && bufHit && !flush;
    // refill has priority over a lookup in the same awake cycle
    fillGo  = fillValid && !flush && awake;
    lookGo  = fetchValid && !bufHit && !flush && awake && !fillValid;
    needTlb = (fetchValid && !bufHit) || fillValid;

    stb.lookup   = lookGo;
    stb.fill     = fillGo;
    stb.flush    = flush;
    stb.cntHit   = hitPath;
    stb.cntSleep = (state == PWR_SLEEP);

    fetchReady = hitPath || lookGo;
    fillReady  = fillGo;
    tlbSleep   = (state == PWR_SLEEP);
  end

  always_comb begin
    stateNext   = state;
    wakeCntNext = wakeCnt;
    unique case (state)
      PWR_SLEEP: begin
        if (needTlb) begin
          stateNext   = PWR_WAKE;
          wakeCntNext = '0;
        end
      end
      PWR_WAKE: begin
        if (wakeCnt == WCNT_W'(WAKE_CYCLES - 1)) stateNext = PWR_AWAKE;
        else wakeCntNext = wakeCnt + WCNT_W'(1);
      end
      PWR_AWAKE: begin
        if (!(lookGo || fillGo)) stateNext = PWR_SLEEP;
      end
      default: stateNext = PWR_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PWR_SLEEP;
      wakeCnt <= '0;
    end else begin
      state   <= stateNext;
      wakeCnt <= wakeCntNext;
    end
  end

  // R2: the wake counter never passes its limit
  a_r2_wake_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == PWR_WAKE) |-> (int'(wakeCnt) < WAKE_CYCLES));

  // R2: a buffer miss while asleep starts the wake sequence
  a_r2_wake_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == PWR_SLEEP && fetchValid && !bufHit) |=> (state == PWR_WAKE));

  // R6: one idle awake cycle sends the array back to sleep
  a_r6_idle_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (state == PWR_AWAKE && !stb.lookup && !stb.fill) |=> (state == PWR_SLEEP));

endmodule

// File: rtl/xfilt_path.sv
module xfilt_path
  import xfilt_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  xfilt_stb_t       stb,
  input  logic [VPN_W-1:0] fetchVpn,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  output logic             bufHit,
  output logic [PPN_W-1:0] xlatPpn,
  output logic             xlatFault,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] accessCount,
  output logic [CNT_W-1:0] sleepCount
);

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] matchVec;
  logic [PPN_W-1:0]   entPpn [ENTRIES];
  logic               tlbHit;
  logic [PPN_W-1:0]   tlbPpn;

  logic               bufValid;
  logic [VPN_W-1:0]   bufVpn;
  logic [PPN_W-1:0]   bufPpn;

  // array entries; valid bits live in always-on flops so flush needs no wake
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             eValid;
    logic [VPN_W-1:0] eVpn;
    logic [PPN_W-1:0] ePpn;
    logic             wrSel;

    assign wrSel = stb.fill && (fillIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        eValid <= 1'b0;
        eVpn   <= '0;
        ePpn   <= '0;
      end else if (stb.flush) begin
        eValid <= 1'b0;
      end else if (wrSel) begin
        eValid <= 1'b1;
        eVpn   <= fillVpn;
        ePpn   <= fillPpn;
      end
    end

    assign entValid[g] = eValid;
    assign entPpn[g]   = ePpn;
    assign matchVec[g] = eValid && (eVpn == fetchVpn);
  end

  // lowest matching index wins
  always_comb begin
    tlbHit = |matchVec;
    tlbPpn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) tlbPpn = entPpn[i];
    end
  end

  // single-entry filter buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      bufVpn   <= '0;
      bufPpn   <= '0;
    end else if (stb.flush) begin
      bufValid <= 1'b0;
    end else if (stb.fill && bufValid && (fillVpn == bufVpn)) begin
      bufPpn <= fillPpn;
    end else if (stb.lookup && tlbHit) begin
      bufValid <= 1'b1;
      bufVpn   <= fetchVpn;
      bufPpn   <= tlbPpn;
    end
  end

  assign bufHit    = bufValid && (bufVpn == fetchVpn);
  assign xlatFault = stb.lookup && !tlbHit;
  assign xlatPpn   = bufHit ? bufPpn : (tlbHit ? tlbPpn : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitCount    <= '0;
      accessCount <= '0;
      sleepCount  <= '0;
    end else begin
      if (stb.cntHit)   hitCount    <= hitCount + CNT_W'(1);
      if (stb.lookup)   accessCount <= accessCount + CNT_W'(1);
      if (stb.cntSleep) sleepCount  <= sleepCount + CNT_W'(1);
    end
  end

  // R1: a buffer hit never triggers an array lookup
  a_r1_hit_no_lookup: assert property (@(posedge clk) disable iff (!rstN)
    bufHit |-> !stb.lookup);

  // R4: a failed lookup leaves the buffer untouched
  a_r4_fault_keeps_buf: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lookup && !tlbHit) |=> (bufValid == $past(bufValid) &&
      bufVpn == $past(bufVpn) && bufPpn == $past(bufPpn)));

  // R5: a successful lookup loads the buffer with the fetched page
  a_r5_hit_loads_buf: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lookup && tlbHit) |=> (bufValid && bufVpn == $past(fetchVpn)));

  // R8: a flush leaves nothing valid
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (!bufValid && entValid == '0));

  // R10: a refill of the buffered page updates the buffer
  a_r10_fill_updates_buf: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fill && bufValid && fillVpn == bufVpn) |=> (bufPpn == $past(fillPpn)));

endmodule

// File: rtl/xfilt_top.sv
module xfilt_top
  import xfilt_pkg::*;
#(
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20,
  parameter int ENTRIES     = 16,
  parameter int WAKE_CYCLES = 3,
  parameter int CNT_W       = 32,
  localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic [VPN_W-1:0] fetchVpn,
  output logic             fetchReady,
  output logic [PPN_W-1:0] xlatPpn,
  output logic             xlatFault,
  input  logic             flush,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  output logic             fillReady,
  output logic             tlbSleep,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] accessCount,
  output logic [CNT_W-1:0] sleepCount
);

  xfilt_stb_t stb;
  logic       bufHit;

  xfilt_ctrl #(
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fetchValid(fetchValid),
    .flush     (flush),
    .fillValid (fillValid),
    .bufHit    (bufHit),
    .fetchReady(fetchReady),
    .fillReady (fillReady),
    .tlbSleep  (tlbSleep),
    .stb       (stb)
  );

  xfilt_path #(
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W),
    .ENTRIES(ENTRIES),
    .CNT_W  (CNT_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .fetchVpn   (fetchVpn),
    .fillIdx    (fillIdx),
    .fillVpn    (fillVpn),
    .fillPpn    (fillPpn),
    .bufHit     (bufHit),
    .xlatPpn    (xlatPpn),
    .xlatFault  (xlatFault),
    .hitCount   (hitCount),
    .accessCount(accessCount),
    .sleepCount (sleepCount)
  );

  // R7: the access counter is frozen across a sleeping cycle
  a_r7_no_access_asleep: assert property (@(posedge clk) disable iff (!rstN)
    tlbSleep |=> (accessCount == $past(accessCount)));

  // R12: every sleeping cycle is counted
  a_r12_sleep_count: assert property (@(posedge clk) disable iff (!rstN)
    tlbSleep |=> (sleepCount == CNT_W'($past(sleepCount) + 1)));

endmodule

// File: tb/xfilt_top_test.sv
`timescale 1ns/1ps
module xfilt_top_test;
  localparam int VW = 6;
  localparam int PW = 6;
  localparam int NE = 4;
  localparam int IW = 2;
  localparam int WK = 2;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fetchValid = 1'b0;
  logic [VW-1:0] fetchVpn = '0;
  logic          fetchReady;
  logic [PW-1:0] xlatPpn;
  logic          xlatFault;
  logic          flush = 1'b0;
  logic          fillValid = 1'b0;
  logic [IW-1:0] fillIdx = '0;
  logic [VW-1:0] fillVpn = '0;
  logic [PW-1:0] fillPpn = '0;
  logic          fillReady;
  logic          tlbSleep;
  logic [CW-1:0] hitCount, accessCount, sleepCount;

  always #10 clk = ~clk;

  xfilt_top #(.VPN_W(VW), .PPN_W(PW), .ENTRIES(NE), .WAKE_CYCLES(WK), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchVpn(fetchVpn),
    .fetchReady(fetchReady), .xlatPpn(xlatPpn), .xlatFault(xlatFault),
    .flush(flush), .fillValid(fillValid), .fillIdx(fillIdx), .fillVpn(fillVpn),
    .fillPpn(fillPpn), .fillReady(fillReady), .tlbSleep(tlbSleep),
    .hitCount(hitCount), .accessCount(accessCount), .sleepCount(sleepCount));

  int checks = 0;
  int errors = 0;

  // reference model
  bit            mV [NE];
  logic [VW-1:0] mVpn [NE];
  logic [PW-1:0] mPpn [NE];
  bit            bV = 1'b0;
  logic [VW-1:0] bVpn = '0;
  logic [PW-1:0] bPpn = '0;
  int            expHits = 0;
  int            expAcc = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit mLook(input logic [VW-1:0] v, output logic [PW-1:0] p);
    for (int i = 0; i < NE; i++) begin
      if (mV[i] && mVpn[i] == v) begin
        p = mPpn[i];
        return 1'b1;
      end
    end
    p = '0;
    return 1'b0;
  endfunction

  function automatic logic [PW-1:0] mapP(input int v);
    return PW'((v * 7 + 3) % 64);
  endfunction

  function automatic int missLat(input logic [VW-1:0] v);
    return (bV && bVpn == v) ? 0 : WK + 1;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // present a fetch at a falling edge, wait for completion, judge it
  task automatic fetchChk(input string tag, input logic [VW-1:0] v, input int expLat);
    logic [PW-1:0] ep;
    bit hit, bh;
    int lat;
    bh = bV && (bVpn == v);
    if (bh) begin
      ep = bPpn;
      hit = 1'b1;
    end else begin
      hit = mLook(v, ep);
    end
    fetchValid = 1'b1;
    fetchVpn = v;
    lat = 0;
    #1;
    while (!fetchReady && lat < 100) begin
      @(negedge clk);
      #1;
      lat++;
    end
    check(tag, "latency", lat, expLat);
    check(tag, "ppn", int'(xlatPpn), int'(ep));
    check(tag, "fault", int'(xlatFault), int'(!hit));
    if (bh) expHits++;
    else begin
      expAcc++;
      if (hit) begin
        bV = 1'b1;
        bVpn = v;
        bPpn = ep;
      end
    end
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  task automatic fillChk(input string tag, input int idx, input logic [VW-1:0] v,
                         input logic [PW-1:0] p, input int expLat);
    int lat;
    fillValid = 1'b1;
    fillIdx = IW'(idx);
    fillVpn = v;
    fillPpn = p;
    lat = 0;
    #1;
    while (!fillReady && lat < 100) begin
      @(negedge clk);
      #1;
      lat++;
    end
    check(tag, "fill latency", lat, expLat);
    mV[idx] = 1'b1;
    mVpn[idx] = v;
    mPpn[idx] = p;
    if (bV && bVpn == v) bPpn = p;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int s0, a0, h0;
    for (int i = 0; i < NE; i++) begin
      mV[i] = 1'b0;
      mVpn[i] = '0;
      mPpn[i] = '0;
    end
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R13 reset state
    check("R13", "tlbSleep", int'(tlbSleep), 1);
    check("R13", "hitCount", int'(hitCount), 0);
    check("R13", "accessCount", int'(accessCount), 0);
    check("R13", "sleepCount", int'(sleepCount), 1);
    // R13 first fetch (VPN 0) must go to the empty TLB and fault
    fetchChk("R13", '0, WK + 1);
    idle(2);

    // R9 refills: first from sleep, the rest while awake
    for (int i = 0; i < NE; i++)
      fillChk("R9", i, VW'(9 * i + 4), mapP(9 * i + 4), (i == 0) ? WK + 1 : 0);
    idle(2);

    // R7 / R12 sleeping window
    s0 = int'(sleepCount);
    a0 = int'(accessCount);
    idle(10);
    check("R12", "sleep delta", int'(sleepCount) - s0, 10);
    check("R7", "no access asleep", int'(accessCount), a0);
    check("R7", "still asleep", int'(tlbSleep), 1);

    // R3 / R4 / R5 / R1 / R2 sweep over every VPN
    for (int v = 0; v < 64; v++) begin
      idle(2);
      fetchChk("R3", VW'(v), missLat(VW'(v)));
      idle(2);
      fetchChk("R5", VW'(v), missLat(VW'(v)));
    end
    check("R12", "hitCount", int'(hitCount), expHits);
    check("R12", "accessCount", int'(accessCount), expAcc);

    // R6 back-to-back lookups while awake, then sleep after one idle cycle
    idle(2);
    fetchChk("R6", VW'(4), WK + 1);
    check("R6", "awake after lookup", int'(tlbSleep), 0);
    fetchChk("R6", VW'(13), 0);
    idle(1);
    check("R6", "asleep after idle", int'(tlbSleep), 1);
    fetchChk("R2", VW'(22), WK + 1);

    // R10 same cycle: buffer hit and refill of buffered page, TLB awake
    h0 = int'(hitCount);
    fetchValid = 1'b1;
    fetchVpn = VW'(22);
    fillValid = 1'b1;
    fillIdx = IW'(2);
    fillVpn = VW'(22);
    fillPpn = PW'(45);
    #1;
    check("R10", "hit ready", int'(fetchReady), 1);
    check("R10", "old ppn", int'(xlatPpn), int'(bPpn));
    check("R10", "fill ready", int'(fillReady), 1);
    @(negedge clk);
    fetchValid = 1'b0;
    fillValid = 1'b0;
    mPpn[2] = PW'(45);
    bPpn = PW'(45);
    expHits++;
    check("R1", "hit counted", int'(hitCount), h0 + 1);
    fetchChk("R10", VW'(22), 0);

    // R10 again with TLB asleep: hit completes, refill waits for wake
    idle(2);
    fetchValid = 1'b1;
    fetchVpn = VW'(22);
    fillValid = 1'b1;
    fillIdx = IW'(2);
    fillVpn = VW'(22);
    fillPpn = PW'(46);
    #1;
    check("R10", "hit ready asleep", int'(fetchReady), 1);
    check("R10", "old ppn asleep", int'(xlatPpn), 45);
    check("R9", "fill stalled", int'(fillReady), 0);
    expHits++;
    @(negedge clk);
    fetchValid = 1'b0;
    begin
      int lat;
      lat = 1;
      #1;
      while (!fillReady && lat < 100) begin
        @(negedge clk);
        #1;
        lat++;
      end
      check("R9", "fill wake latency", lat, WK + 1);
    end
    mPpn[2] = PW'(46);
    bPpn = PW'(46);
    @(negedge clk);
    fillValid = 1'b0;
    fetchChk("R10", VW'(22), 0);

    // R11 refill and lookup pending together while awake
    idle(2);
    fetchChk("R4", VW'(40), WK + 1);
    fetchValid = 1'b1;
    fetchVpn = VW'(40);
    fillValid = 1'b1;
    fillIdx = IW'(0);
    fillVpn = VW'(40);
    fillPpn = PW'(33);
    #1;
    check("R11", "lookup waits", int'(fetchReady), 0);
    check("R11", "refill first", int'(fillReady), 1);
    @(negedge clk);
    fillValid = 1'b0;
    mV[0] = 1'b1;
    mVpn[0] = VW'(40);
    mPpn[0] = PW'(33);
    #1;
    check("R11", "lookup next", int'(fetchReady), 1);
    check("R11", "new ppn", int'(xlatPpn), 33);
    check("R11", "no fault", int'(xlatFault), 0);
    expAcc++;
    bV = 1'b1;
    bVpn = VW'(40);
    bPpn = PW'(33);
    @(negedge clk);
    fetchValid = 1'b0;

    // R3 duplicate VPNs: lowest index wins
    fillChk("R3", 3, VW'(50), PW'(11), 0);
    fillChk("R3", 1, VW'(50), PW'(12), 0);
    fetchChk("R3", VW'(50), 0);
    check("R3", "lowest index", int'(bPpn), 12);

    // R8 flush: blocks a buffer hit, then everything faults
    fetchValid = 1'b1;
    fetchVpn = VW'(50);
    flush = 1'b1;
    #1;
    check("R8", "no completion in flush", int'(fetchReady), 0);
    @(negedge clk);
    flush = 1'b0;
    fetchValid = 1'b0;
    for (int i = 0; i < NE; i++) mV[i] = 1'b0;
    bV = 1'b0;
    idle(2);
    fetchChk("R8", VW'(50), WK + 1);
    idle(2);
    fetchChk("R8", VW'(13), WK + 1);

    idle(2);
    check("R12", "final hitCount", int'(hitCount), expHits);
    check("R12", "final accessCount", int'(accessCount), expAcc);

    summary();
    $finish;
  end
endmodule